// File: doc/BRIEF.md
# Flag-Preserving Increment Unit

This execution unit adds one to a 64-bit destination operand at a selected width of 8, 16, 32 or 64 bits. It returns the new destination value and an updated six-bit status word. The sum is merged into the operand by width: the two narrow sizes keep the operand's upper bits, the 32-bit size clears them, and the 64-bit size replaces the whole word. Overflow, sign, zero, auxiliary-carry and parity are recomputed from the operation, while the incoming carry bit is copied through untouched. A loop counter can therefore advance without disturbing a pending carry.

The unit sits behind an issue stage that presents one operation per valid cycle. With the default configuration, the result and flags appear one clock after `valid_i`, together with `valid_o`. A parameter removes the register stage and makes the path purely combinational.

Top module: `incr_exec_unit`

## Requirements
- R1: When `valid_o` is high, the low w bits of `result_o` equal the captured operand's low w bits plus one, modulo 2^w. The width w is 8, 16, 32 or 64.
- R2: Flag bit 0 (carry) of `flags_o` equals bit 0 of the captured `flags_i` for every size and operand, including operands that wrap to zero.
- R3: `size_i` selects the width w: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. For 8 and 16, `result_o` bits above w equal the operand's bits. For 32, `result_o[63:32]` is zero.
- R4: Flag bit 3 (zero) is set exactly when the low w bits of the result are all zero.
- R5: Flag bit 4 (sign) equals bit w-1 of the result.
- R6: Flag bit 5 (overflow) is set exactly when the operand's low w bits equal the largest positive signed value of width w.
- R7: Flag bit 2 (auxiliary carry) is set exactly when the operand's bits 3:0 are all ones.
- R8: Flag bit 1 (parity) is set exactly when `result_o[7:0]` holds an even number of ones, whatever the size.
- R9: An operation presented with `valid_i` high appears on the outputs after the next rising clock edge, with `valid_o` high. While `valid_i` is low, `valid_o` falls and `result_o` and `flags_o` hold their last values.
- R10: During and after reset, until the first valid operation, `valid_o`, `result_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present |
| operand_i | input | 64 | Destination operand |
| size_i | input | 2 | Operand width select |
| flags_i | input | 6 | Incoming status word |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | New destination value |
| flags_o | output | 6 | Updated status word |

## Verification
Random 64-bit operands almost never hit the signed-maximum or all-ones patterns that set overflow and zero, and they rarely have a low nibble of all ones. The stimulus therefore builds operands from a per-width pattern: it takes a random value and forces its low w bits to the signed maximum, all ones, the most negative value, or a nibble ending in 0xF. The upper bits stay random, so the merge rules of R3 are exercised on the same operands. Each of these patterns is run with the incoming carry both set and clear.

// File: rtl/incr_pkg.sv
package incr_pkg;
  localparam int DATA_W    = 64;
  localparam int NUM_SIZES = 4;
  localparam int SIZE_W    = $clog2(NUM_SIZES);
  localparam int FLAG_W    = 6;

  typedef enum logic [SIZE_W-1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;
endpackage

// File: rtl/incr_adder.sv
module incr_adder
  import incr_pkg::*;
(
  input  logic [DATA_W-1:0] op_i,
  input  size_e             size_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] lane_sum [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    if (LW == DATA_W) begin : g_full
      assign lane_sum[g] = op_i + DATA_W'(1);
    end else begin : g_part
      assign lane_sum[g] = {{(DATA_W-LW){1'b0}}, op_i[LW-1:0] + LW'(1)};
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_B:    res_o = {op_i[DATA_W-1:8],  lane_sum[0][7:0]};
      SZ_H:    res_o = {op_i[DATA_W-1:16], lane_sum[1][15:0]};
      SZ_W:    res_o = lane_sum[2];  // upper half cleared
      default: res_o = lane_sum[3];
    endcase
  end
endmodule

// File: rtl/incr_flags.sv
module incr_flags
  import incr_pkg::*;
(
  input  logic [DATA_W-1:0] op_i,
  input  logic [DATA_W-1:0] res_i,
  input  size_e             size_i,
  input  flags_t            flags_i,
  output flags_t            flags_o
);
  logic [NUM_SIZES-1:0] lane_zro, lane_sgn, lane_ovf;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    assign lane_zro[g] = (res_i[LW-1:0] == '0);
    assign lane_sgn[g] = res_i[LW-1];
    assign lane_ovf[g] = (op_i[LW-1:0] == SMAX);
  end

  always_comb begin
    flags_o.ovf = lane_ovf[size_i];
    flags_o.sgn = lane_sgn[size_i];
    flags_o.zro = lane_zro[size_i];
    flags_o.aux = &op_i[3:0];
    flags_o.par = ~^res_i[7:0];
    flags_o.cry = flags_i.cry;  // carry untouched
  end
endmodule

// File: rtl/incr_out_stage.sv
module incr_out_stage
  import incr_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] res_i,
  input  flags_t            flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        res_o   <= '0;
        flags_o <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          res_o   <= res_i;
          flags_o <= flags_i;
        end
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign res_o   = res_i;
    assign flags_o = flags_i;
  end
endmodule

// File: rtl/incr_exec_unit.sv
module incr_exec_unit
  import incr_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [63:0]       operand_i,
  input  logic [1:0]        size_i,
  input  logic [5:0]        flags_i,
  output logic              valid_o,
  output logic [63:0]       result_o,
  output logic [5:0]        flags_o
);
  size_e             size;
  flags_t            flags_in, flags_nxt, flags_q;
  logic [DATA_W-1:0] sum;

  assign size     = size_e'(size_i);
  assign flags_in = flags_t'(flags_i);

  incr_adder u_adder (
    .op_i   (operand_i),
    .size_i (size),
    .res_o  (sum)
  );

  incr_flags u_flags (
    .op_i    (operand_i),
    .res_i   (sum),
    .size_i  (size),
    .flags_i (flags_in),
    .flags_o (flags_nxt)
  );

  incr_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .res_i   (sum),
    .flags_i (flags_nxt),
    .valid_o (valid_o),
    .res_o   (result_o),
    .flags_o (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/incr_exec_unit_chk.sv
module incr_exec_unit_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [63:0] operand_i,
  input logic [1:0]  size_i,
  input logic [5:0]  flags_i,
  input logic        valid_o,
  input logic [63:0] result_o,
  input logic [5:0]  flags_o
);
  logic [63:0] src_op;
  logic [1:0]  src_sz;
  logic        src_cf;
  logic        seen;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_op <= '0;
        src_sz <= '0;
        src_cf <= 1'b0;
        seen   <= 1'b0;
      end else if (valid_i) begin
        src_op <= operand_i;
        src_sz <= size_i;
        src_cf <= flags_i[0];
        seen   <= 1'b1;
      end
    end
  end else begin : g_comb
    assign src_op = operand_i;
    assign src_sz = size_i;
    assign src_cf = flags_i[0];
    assign seen   = 1'b1;
  end

  logic [63:0] mask;
  logic        msb;
  always_comb begin
    case (src_sz)
      2'd0:    mask = 64'hFF;
      2'd1:    mask = 64'hFFFF;
      2'd2:    mask = 64'hFFFF_FFFF;
      default: mask = '1;
    endcase
    msb = |(result_o & (mask ^ (mask >> 1)));
  end

  p_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((result_o & mask) == ((src_op + 64'd1) & mask)));
  p_carry_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[0] == src_cf));
  p_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && src_sz == 2'd2) |-> (result_o[63:32] == 32'h0));
  p_upper_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && src_sz == 2'd0) |-> (result_o[63:8] == src_op[63:8]));
  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[3] == ((result_o & mask) == 64'h0)));
  p_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[4] == msb));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[5]) |-> (flags_o[4] && !flags_o[3]));
  p_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[1] == ~^result_o[7:0]));
  if (REG_OUT) begin : g_hs
    p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> ($stable(result_o) && $stable(flags_o) && !valid_o));
    p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen |-> (result_o == 64'h0 && flags_o == 6'h0 && !valid_o));
  end
endmodule

bind incr_exec_unit incr_exec_unit_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/incr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module incr_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [1:0]  size_i = '0;
  logic [5:0]  flags_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [5:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  incr_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .operand_i(operand_i),
    .size_i(size_i), .flags_i(flags_i), .valid_o(valid_o),
    .result_o(result_o), .flags_o(flags_o)
  );

  function automatic logic [63:0] wmask(logic [1:0] s);
    return (s == 2'd3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  function automatic logic [63:0] exp_res(logic [63:0] op, logic [1:0] s);
    logic [63:0] m = wmask(s);
    logic [63:0] r = (op + 64'd1) & m;
    if (s == 2'd2 || s == 2'd3) return r;
    return (op & ~m) | r;
  endfunction

  function automatic logic [5:0] exp_flg(logic [63:0] op, logic [1:0] s, logic [5:0] fi);
    logic [63:0] m = wmask(s);
    logic [63:0] r = exp_res(op, s);
    logic [5:0]  f;
    int          w = 8 << s;
    f[0] = fi[0];
    f[1] = ~^r[7:0];
    f[2] = (op[3:0] == 4'hF);
    f[3] = ((r & m) == 64'h0);
    f[4] = r[w-1];
    f[5] = ((op & m) == (m >> 1));
    return f;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [63:0] op, logic [1:0] s, logic [5:0] fi);
    logic [63:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    valid_i = 1'b1; operand_i = op; size_i = s; flags_i = fi;
    @(negedge clk);
    valid_i = 1'b0;
    er = exp_res(op, s);
    ef = exp_flg(op, s, fi);
    chk("R9 valid_o", 64'(valid_o), 64'd1);
    chk("R1 R3 result", result_o, er);
    chk("R2 carry", 64'(flags_o[0]), 64'(ef[0]));
    chk("R8 parity", 64'(flags_o[1]), 64'(ef[1]));
    chk("R7 aux", 64'(flags_o[2]), 64'(ef[2]));
    chk("R4 zero", 64'(flags_o[3]), 64'(ef[3]));
    chk("R5 sign", 64'(flags_o[4]), 64'(ef[4]));
    chk("R6 overflow", 64'(flags_o[5]), 64'(ef[5]));
  endtask

  function automatic logic [63:0] shape(logic [63:0] base, logic [1:0] s, int kind);
    logic [63:0] m = wmask(s);
    case (kind)
      0: return (base & ~m) | (m >> 1);               // signed max
      1: return base | m;                             // all ones
      2: return (base & ~m) | ((m >> 1) + 64'd1);     // most negative
      3: return base | 64'hF;                         // nibble carry
      default: return base;
    endcase
  endfunction

  initial begin
    int seed = 32'h1C0DE;
    void'($urandom(seed));
    #1;
    chk("R10 reset valid", 64'(valid_o), 64'd0);
    chk("R10 reset result", result_o, 64'd0);
    chk("R10 reset flags", 64'(flags_o), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle result", result_o, 64'd0);
    chk("R10 idle flags", 64'(flags_o), 64'd0);

    // directed corners
    run_op(64'hAAAA_BBBB_CCCC_DD7F, 2'd0, 6'h00);
    run_op(64'h1234_5678_9ABC_FFFF, 2'd1, 6'h01);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 6'h01);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 6'h00);
    run_op(64'hDEAD_BEEF_7FFF_FFFF, 2'd2, 6'h3F);
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 6'h00);
    run_op(64'h5555_0000_0000_00FF, 2'd0, 6'h01);
    run_op(64'h0000_0000_0000_0000, 2'd3, 6'h3E);

    // R9 hold: inputs change with valid low
    @(negedge clk);
    operand_i = 64'h0123_4567_89AB_CDEF; size_i = 2'd3; flags_i = 6'h3F;
    @(negedge clk);
    chk("R9 valid low", 64'(valid_o), 64'd0);
    chk("R9 hold result", result_o, exp_res(64'h0, 2'd3));
    chk("R9 hold flags", 64'(flags_o), 64'(exp_flg(64'h0, 2'd3, 6'h3E)));

    // shaped random
    for (int i = 0; i < 600; i++) begin
      logic [63:0] b = {$urandom(), $urandom()};
      logic [1:0]  s = 2'($urandom_range(0, 3));
      int          k = $urandom_range(0, 5);
      logic [5:0]  fi = 6'($urandom());
      run_op(shape(b, s, k), s, fi);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule